// File: doc/BRIEF.md
# Timing Receiver Link Bring-Up Controller

This block steps a timing receiver endpoint from an idle condition to an operational one. Each stage waits for one condition flag from the physical or decode layer. The stages are, in order: optical signal seen, clock recovery locked, frequency check passed, comma alignment found, a clean 8b/10b packet received, and timestamp initialised. The current stage is published as a 4-bit status code, and a ready flag is raised once every stage is complete.

After clock recovery has locked, the controller watches for faults. Losing signal or lock sends it to a physical-fault state. A decode error from the packet stage onward sends it to a receive-error state. A timestamp mismatch while operational sends it to a timestamp-error state. Every error state holds until software pulses a synchronous reset or drops the enable. Either action returns the block to standby. The serial receiver, the decoder and the timestamp counter sit outside this block and provide only their single-bit flags.

States and their codes are as follows:
- ST_STANDBY (0x0)
- ST_WAIT_SIGNAL (0x1)
- ST_WAIT_CDR (0x2)
- ST_WAIT_FREQ (0x3)
- ST_WAIT_COMMA (0x4)
- ST_WAIT_PACKET (0x5)
- ST_WAIT_TSINIT (0x6)
- ST_OPERATIONAL (0x8)
- ST_ERR_RX (0xc)
- ST_ERR_TSCHK (0xd)
- ST_ERR_PHY (0xe)

Transitions are as follows:
- standby→signal on enable.
- signal→cdr on `sig_present`.
- cdr→signal when the signal is lost.
- cdr→freq on `cdr_locked`.
- freq→comma on `freq_good`.
- comma→packet on `comma_aligned`.
- packet→tsinit on `packet_good`.
- tsinit→operational on `ts_initialised`.
- any locked state (0x3–0x8)→phy-error when the signal or lock is lost.
- packet, tsinit or operational→rx-error on `decode_err`.
- operational→tscheck-error on `ts_mismatch`.
- any state→standby on a low enable or on `sw_reset`.

Top module: `link_bringup_fsm`

## Requirements
- R1: While `rst_n` is low and in the cycle after its release, `status` is 0x0 and `ready` is 0.
- R2: When `enable` is low at a clock edge, `status` is 0x0 after that edge, whatever the prior state.
- R3: When `sw_reset` is high at a clock edge, `status` is 0x0 after that edge. With `enable` still high, the next edge then moves it to 0x1.
- R4: In standby (0x0) with `enable` high and `sw_reset` low, one edge moves `status` to 0x1.
- R5: The wait stages advance only when their own flag is high, and otherwise hold their code. The stages and flags are:
  - 0x1 advances to 0x2 on `sig_present`.
  - 0x2 advances to 0x3 on `cdr_locked`.
  - 0x3 advances to 0x4 on `freq_good`.
  - 0x4 advances to 0x5 on `comma_aligned`.
  - 0x5 advances to 0x6 on `packet_good`.
  - 0x6 advances to 0x8 on `ts_initialised`.
- R6: In 0x2, if `sig_present` is low, the next code is 0x1.
- R7: In any of 0x3, 0x4, 0x5, 0x6 or 0x8, if `sig_present` or `cdr_locked` is low, the next code is 0xe.
- R8: In 0x5, 0x6 or 0x8, a high `decode_err` with signal and lock present gives 0xc next. In 0x1 through 0x4, `decode_err` has no effect.
- R9: In 0x8, a high `ts_mismatch` with no physical fault and no decode error gives 0xd next. In every other state, `ts_mismatch` has no effect.
- R10: `ready` is 1 exactly when `status` is 0x8.
- R11: Codes 0xc, 0xd and 0xe hold while `enable` is high and `sw_reset` is low, whatever the condition flags do.
- R12: When several faults occur in the same cycle, the physical fault (0xe) wins over the decode error (0xc), and the decode error wins over the timestamp mismatch (0xd).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Endpoint enable; low forces standby |
| sw_reset | input | 1 | Synchronous software reset to standby |
| sig_present | input | 1 | Optical receiver sees a signal |
| cdr_locked | input | 1 | Clock-data recovery is locked |
| freq_good | input | 1 | Recovered frequency check passed |
| comma_aligned | input | 1 | Comma alignment achieved |
| packet_good | input | 1 | Decoder delivered a valid packet |
| ts_initialised | input | 1 | Timestamp has been initialised |
| decode_err | input | 1 | Decoder reported a receive error |
| ts_mismatch | input | 1 | Timestamp check failed |
| status | output | 4 | Bring-up status code |
| ready | output | 1 | Endpoint operational |

## Verification
The assertions assume that all condition flags are synchronous to `clk` and settle before each edge. They also assume that `enable` and `sw_reset` are plain levels, sampled at the same edge as the flags. The bench changes every input only on the falling clock edge and samples `status` and `ready` at the following falling edge. Each sample therefore reflects exactly one rising edge's decision. Fault flags are raised only with the lower-priority conditions set deliberately, so each priority case is reached on purpose.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

    localparam int STATUS_W = 4;

    typedef enum logic [STATUS_W-1:0] {
        ST_STANDBY     = 4'h0,
        ST_WAIT_SIGNAL = 4'h1,
        ST_WAIT_CDR    = 4'h2,
        ST_WAIT_FREQ   = 4'h3,
        ST_WAIT_COMMA  = 4'h4,
        ST_WAIT_PACKET = 4'h5,
        ST_WAIT_TSINIT = 4'h6,
        ST_OPERATIONAL = 4'h8,
        ST_ERR_RX      = 4'hc,
        ST_ERR_TSCHK   = 4'hd,
        ST_ERR_PHY     = 4'he
    } lbu_state_e;

    typedef struct packed {
        logic sig;
        logic cdr;
        logic freq;
        logic comma;
        logic pkt;
        logic tsinit;
        logic dec_err;
        logic ts_bad;
    } lbu_flags_t;

endpackage

// File: rtl/lbu_next_state.sv
module lbu_next_state
    import lbu_pkg::*;
(
    input  lbu_state_e cur,
    input  logic       enable,
    input  logic       sw_reset,
    input  lbu_flags_t fl,
    output lbu_state_e nxt
);

    logic phy_fault;

    always_comb begin
        phy_fault = !fl.sig || !fl.cdr;
        nxt = cur;
        if (!enable || sw_reset) begin
            nxt = ST_STANDBY;
        end else begin
            unique case (cur)
                ST_STANDBY:     nxt = ST_WAIT_SIGNAL;
                ST_WAIT_SIGNAL: if (fl.sig) nxt = ST_WAIT_CDR;
                ST_WAIT_CDR: begin
                    if (!fl.sig)     nxt = ST_WAIT_SIGNAL;
                    else if (fl.cdr) nxt = ST_WAIT_FREQ;
                end
                ST_WAIT_FREQ: begin
                    if (phy_fault)    nxt = ST_ERR_PHY;
                    else if (fl.freq) nxt = ST_WAIT_COMMA;
                end
                ST_WAIT_COMMA: begin
                    if (phy_fault)     nxt = ST_ERR_PHY;
                    else if (fl.comma) nxt = ST_WAIT_PACKET;
                end
                ST_WAIT_PACKET: begin
                    if (phy_fault)       nxt = ST_ERR_PHY;
                    else if (fl.dec_err) nxt = ST_ERR_RX;
                    else if (fl.pkt)     nxt = ST_WAIT_TSINIT;
                end
                ST_WAIT_TSINIT: begin
                    if (phy_fault)       nxt = ST_ERR_PHY;
                    else if (fl.dec_err) nxt = ST_ERR_RX;
                    else if (fl.tsinit)  nxt = ST_OPERATIONAL;
                end
                ST_OPERATIONAL: begin
                    if (phy_fault)       nxt = ST_ERR_PHY;
                    else if (fl.dec_err) nxt = ST_ERR_RX;
                    else if (fl.ts_bad)  nxt = ST_ERR_TSCHK;
                end
                ST_ERR_RX, ST_ERR_TSCHK, ST_ERR_PHY: nxt = cur;
                default: nxt = ST_STANDBY;
            endcase
        end
    end

endmodule

// File: rtl/lbu_status_out.sv
module lbu_status_out
    import lbu_pkg::*;
(
    input  lbu_state_e          cur,
    output logic [STATUS_W-1:0] status,
    output logic                ready
);

    always_comb begin
        status = cur;
        ready  = 1'b0;
        unique case (cur)
            ST_OPERATIONAL: ready = 1'b1;
            default:        ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/link_bringup_fsm.sv
module link_bringup_fsm
    import lbu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       sw_reset,
    input  logic       sig_present,
    input  logic       cdr_locked,
    input  logic       freq_good,
    input  logic       comma_aligned,
    input  logic       packet_good,
    input  logic       ts_initialised,
    input  logic       decode_err,
    input  logic       ts_mismatch,
    output logic [3:0] status,
    output logic       ready
);

    lbu_state_e state_q;
    lbu_state_e state_d;
    lbu_flags_t flags;

    always_comb begin
        flags.sig     = sig_present;
        flags.cdr     = cdr_locked;
        flags.freq    = freq_good;
        flags.comma   = comma_aligned;
        flags.pkt     = packet_good;
        flags.tsinit  = ts_initialised;
        flags.dec_err = decode_err;
        flags.ts_bad  = ts_mismatch;
    end

    lbu_next_state u_next (
        .cur      (state_q),
        .enable   (enable),
        .sw_reset (sw_reset),
        .fl       (flags),
        .nxt      (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    lbu_status_out u_out (
        .cur    (state_q),
        .status (status),
        .ready  (ready)
    );

    logic run_ok;
    logic locked_code;
    logic err_code;
    always_comb begin
        run_ok      = enable && !sw_reset;
        locked_code = (status >= 4'h3) && (status <= 4'h8) && (status != 4'h7);
        err_code    = (status == 4'hc) || (status == 4'hd) || (status == 4'he);
    end

    assert_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> status == 4'h0);

    assert_swreset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> status == 4'h0);

    assert_hold_signal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && status == 4'h1 && !sig_present) |=> status == 4'h1);

    assert_phy_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && locked_code && (!sig_present || !cdr_locked)) |=> status == 4'he);

    assert_ts_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && ready && sig_present && cdr_locked && !decode_err && ts_mismatch)
        |=> status == 4'hd);

    assert_ready_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(status) == 4'h6);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && err_code) |=> $stable(status));

endmodule

// File: tb/link_bringup_fsm_test.sv
module link_bringup_fsm_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, sw_reset = 1'b0;
    logic sig_present = 1'b0, cdr_locked = 1'b0, freq_good = 1'b0;
    logic comma_aligned = 1'b0, packet_good = 1'b0, ts_initialised = 1'b0;
    logic decode_err = 1'b0, ts_mismatch = 1'b0;
    logic [3:0] status;
    logic ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    link_bringup_fsm uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sw_reset(sw_reset),
        .sig_present(sig_present), .cdr_locked(cdr_locked), .freq_good(freq_good),
        .comma_aligned(comma_aligned), .packet_good(packet_good),
        .ts_initialised(ts_initialised), .decode_err(decode_err),
        .ts_mismatch(ts_mismatch), .status(status), .ready(ready)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_code(input string req, input logic [3:0] exp);
        check(req, status, exp);
        check({req, " ready"}, {3'b0, ready}, {3'b0, exp == 4'h8});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flags();
        sig_present = 0; cdr_locked = 0; freq_good = 0; comma_aligned = 0;
        packet_good = 0; ts_initialised = 0; decode_err = 0; ts_mismatch = 0;
    endtask

    task automatic restart();
        clear_flags();
        enable = 0; sw_reset = 0;
        step();
        enable = 1;
        step();
    endtask

    task automatic climb(input int stages);
        for (int i = 1; i <= stages; i++) begin
            case (i)
                1: sig_present = 1;
                2: cdr_locked = 1;
                3: freq_good = 1;
                4: comma_aligned = 1;
                5: packet_good = 1;
                default: ts_initialised = 1;
            endcase
            step();
        end
    endtask

    task automatic t_reset();
        #5 check_code("R1 in reset", 4'h0);
        @(negedge clk);
        rst_n = 1;
        step();
        check_code("R1 after release", 4'h0);
    endtask

    task automatic t_sequence();
        restart();
        check_code("R4 standby to signal", 4'h1);
        step();
        check_code("R5 hold at 0x1", 4'h1);
        sig_present = 1; step(); check_code("R5 to 0x2", 4'h2);
        step(); check_code("R5 hold at 0x2", 4'h2);
        cdr_locked = 1; step(); check_code("R5 to 0x3", 4'h3);
        step(); check_code("R5 hold at 0x3", 4'h3);
        freq_good = 1; step(); check_code("R5 to 0x4", 4'h4);
        comma_aligned = 1; step(); check_code("R5 to 0x5", 4'h5);
        step(); check_code("R5 hold at 0x5", 4'h5);
        packet_good = 1; step(); check_code("R5 to 0x6", 4'h6);
        step(); check_code("R10 not ready at 0x6", 4'h6);
        ts_initialised = 1; step(); check_code("R10 ready at 0x8", 4'h8);
    endtask

    task automatic t_loss_before_lock();
        restart();
        climb(1);
        check_code("R6 at 0x2", 4'h2);
        sig_present = 0; step();
        check_code("R6 back to 0x1", 4'h1);
    endtask

    task automatic t_phy_fault();
        restart();
        climb(3);
        check_code("R7 at 0x4", 4'h4);
        cdr_locked = 0; step();
        check_code("R7 lock loss", 4'he);
        climb(6); step();
        check_code("R11 phy sticky", 4'he);
        restart(); climb(6);
        sig_present = 0; step();
        check_code("R7 signal loss in 0x8", 4'he);
        enable = 0; step();
        check_code("R2 error to standby", 4'h0);
    endtask

    task automatic t_rx_error();
        restart();
        climb(2);
        decode_err = 1; step();
        check_code("R8 ignored at 0x3", 4'h3);
        decode_err = 0; climb(4);
        check_code("R8 at 0x5", 4'h5);
        decode_err = 1; step();
        check_code("R8 decode err", 4'hc);
        decode_err = 0; step(); step();
        check_code("R11 rx sticky", 4'hc);
    endtask

    task automatic t_ts_error();
        restart();
        climb(5);
        check_code("R9 at 0x6", 4'h6);
        ts_mismatch = 1; step();
        check_code("R9 ignored at 0x6", 4'h6);
        ts_initialised = 1; step();
        check_code("R9 reached ready", 4'h8);
        step();
        check_code("R9 mismatch in ready", 4'hd);
        ts_mismatch = 0; step();
        check_code("R11 ts sticky", 4'hd);
    endtask

    task automatic t_priority();
        restart(); climb(6);
        decode_err = 1; ts_mismatch = 1; step();
        check_code("R12 rx over ts", 4'hc);
        restart(); climb(6);
        cdr_locked = 0; decode_err = 1; ts_mismatch = 1; step();
        check_code("R12 phy over rx", 4'he);
    endtask

    task automatic t_sw_reset();
        restart(); climb(6);
        sw_reset = 1; step();
        check_code("R3 sw reset", 4'h0);
        sw_reset = 0; step();
        check_code("R3 restart", 4'h1);
        climb(2);
        enable = 0; step();
        check_code("R2 disable from 0x3", 4'h0);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_loss_before_lock();
        t_phy_fault();
        t_rx_error();
        t_ts_error();
        t_priority();
        t_sw_reset();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule